// File: doc/BRIEF.md
# Configurable Logic Element with Lookup Table

This block is the basic logic element of a programmable tile. Four tile pins feed four input selectors. Each selector passes one pin, the element's own flip-flop output, or a constant zero to one address bit of a 4-input lookup table. The table output leaves the element either directly or through a flip-flop on the user clock, depending on a mode bit.

All of the element's configuration sits in one serial shift register on a separate scan clock. It holds the mode bit, four 3-bit select codes and sixteen table bits. A second load pass of the same length pushes the old configuration out of a serial output, so configuration can be read back for checking.

The user clock and its synchronous active-low reset drive only the output flip-flop. They never touch the configuration.

Top module: `cfg_logic_element`

## Requirements
- R1: The configuration image is 29 bits, indexed 0 to 28. Index 0 is the mode bit. Indices 1+3j to 3+3j hold select code j, most significant bit first, for j = 0 to 3. Index 13+k holds table bit k. The image is shifted in from index 28 down to index 0, one bit per rising scan_clk edge while scan_en is high.
- R2: While scan_en is low, scan_clk edges leave the configuration unchanged. User clock edges never change the configuration.
- R3: scan_dout shows the bit at the far end of the chain. If 29 bits are captured before each shift edge of a new load pass, they equal the previously loaded image in its own shift-in order (index 28 first).
- R4: The table output is table bit k. The address k has select 0's source as bit 0 and select 3's source as bit 3.
- R5: Select codes 0 to 3 pick tile pins 0 to 3.
- R6: Select code 4 picks the element's own flip-flop output as feedback.
- R7: Select codes 5, 6 and 7 force that address bit to 0.
- R8: A mode bit of 1 drives le_out straight from the table output. Pin changes show up with no clock edge.
- R9: A mode bit of 0 drives le_out from a flip-flop. The flip-flop loads the table output on each rising clk edge and holds between edges.
- R10: With rst_n low at a rising clk edge, the flip-flop clears to 0. The reset has priority over the table value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Configuration shift clock |
| scan_en | input | 1 | Shift enable for the configuration chain |
| scan_din | input | 1 | Serial configuration data in |
| scan_dout | output | 1 | Serial configuration data out (far end of chain) |
| clk | input | 1 | User clock for the output flip-flop |
| rst_n | input | 1 | Synchronous active-low reset of the output flip-flop |
| pin_in | input | 4 | Tile input pins |
| le_out | output | 1 | Element output |

## Verification
The bench builds the element with its default parameters: four tile pins, a 4-input table and 3-bit select codes. This gives a 29-bit image whose bit positions the bench computes by itself. Because the code space has eight values and only six carry meaning, the spare codes 6 and 7 can be reached and are tested next to code 5. The same width also makes the feedback code 4 and a full readback pass of 29 shifts short enough to test directly.

// File: rtl/le_pkg.sv
// Package: shared layout helpers for the logic element configuration image.
// Assumes the image holds the mode bit, then the select codes (MSB first),
// then the table bits, at increasing bit indices.
package le_pkg;

    // Bit index of the mode flag inside the configuration image.
    localparam int MODE_POS = 0;

    // Total number of configuration bits for a K-input table with W-bit selects.
    function automatic int chain_len(input int k, input int w);
        return 1 + k * w + (1 << k);
    endfunction

    // Image index of bit b (b = w-1 is the MSB) of select code j.
    function automatic int sel_bit_pos(input int j, input int b, input int w);
        return 1 + j * w + (w - 1 - b);
    endfunction

    // Image index of table bit idx.
    function automatic int lut_pos(input int k, input int w, input int idx);
        return 1 + k * w + idx;
    endfunction

endpackage

// File: rtl/le_scan_chain.sv
// Module: serial configuration shift register on the scan clock.
// A new bit enters at index 0 and everything moves one place up.
// The far end (highest index) is the serial output.
// Assumes no reset: contents are defined only after a full load.
module le_scan_chain #(
    parameter int LEN = 29
) (
    input  logic           scan_clk,
    input  logic           scan_en,
    input  logic           scan_din,
    output logic [LEN-1:0] chain_q,
    output logic           scan_dout
);

    // Shift one place per enabled scan edge; otherwise hold.
    always_ff @(posedge scan_clk) begin
        if (scan_en) begin
            chain_q <= {chain_q[LEN-2:0], scan_din};
        end
    end

    // The far end of the chain is the readback bit.
    assign scan_dout = chain_q[LEN-1];

endmodule

// File: rtl/le_cfg_decode.sv
// Module: splits the flat configuration image into mode, select codes and
// table bits. Pure wiring, laid out by the package helpers.
// Assumes LEN equals le_pkg::chain_len(LUT_K, SEL_W).
module le_cfg_decode #(
    parameter int LUT_K = 4,
    parameter int SEL_W = 3,
    parameter int LEN   = 29
) (
    input  logic [LEN-1:0]               chain_q,
    output logic                         comb_mode,
    output logic [LUT_K-1:0][SEL_W-1:0]  sel_codes,
    output logic [(1<<LUT_K)-1:0]        lut_bits
);
    localparam int LUT_SIZE = 1 << LUT_K;

    // Mode flag sits at the lowest image index.
    assign comb_mode = chain_q[le_pkg::MODE_POS];

    // Each select code is taken MSB first from its slot.
    for (genvar j = 0; j < LUT_K; j++) begin : g_sel
        for (genvar b = 0; b < SEL_W; b++) begin : g_bit
            assign sel_codes[j][b] = chain_q[le_pkg::sel_bit_pos(j, b, SEL_W)];
        end
    end

    // Table bits follow the select codes in ascending order.
    for (genvar i = 0; i < LUT_SIZE; i++) begin : g_lut
        assign lut_bits[i] = chain_q[le_pkg::lut_pos(LUT_K, SEL_W, i)];
    end

endmodule

// File: rtl/le_input_sel.sv
// Module: one table-input selector. Codes below PIN_NUM pick a tile pin.
// Code PIN_NUM picks the feedback bit. Any higher code gives 0.
// Assumes 2**SEL_W >= PIN_NUM + 2 (checked at elaboration).
module le_input_sel #(
    parameter int PIN_NUM = 4,
    parameter int SEL_W   = 3
) (
    input  logic [PIN_NUM-1:0] pin_in,
    input  logic               fb_in,
    input  logic [SEL_W-1:0]   code,
    output logic               sel_o
);
    localparam int FB_CODE = PIN_NUM;

    if ((PIN_NUM + 2) > (1 << SEL_W)) begin : g_bad_width
        $error("select width too small for pin count");
    end

    // Compare the code against every legal source; default is constant zero.
    always_comb begin
        sel_o = 1'b0;
        for (int p = 0; p < PIN_NUM; p++) begin
            if (code == SEL_W'(p)) begin
                sel_o = pin_in[p];
            end
        end
        if (code == SEL_W'(FB_CODE)) begin
            sel_o = fb_in;
        end
    end

endmodule

// File: rtl/le_lut.sv
// Module: K-input lookup table. The address is little-endian in the
// selector order: selector 0 drives address bit 0.
module le_lut #(
    parameter int LUT_K = 4
) (
    input  logic [LUT_K-1:0]      addr,
    input  logic [(1<<LUT_K)-1:0] table_bits,
    output logic                  lut_o
);

    // Read the addressed table bit.
    assign lut_o = table_bits[addr];

endmodule

// File: rtl/le_out_stage.sv
// Module: output flip-flop on the user clock with synchronous active-low
// clear, and the mode mux that picks the direct or registered output.
module le_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic comb_mode,
    input  logic lut_o,
    output logic ff_q,
    output logic le_out
);

    // Register the table output; the reset clears it on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q <= 1'b0;
        end else begin
            ff_q <= lut_o;
        end
    end

    // The mode bit chooses the direct path (1) or the flop (0).
    assign le_out = comb_mode ? lut_o : ff_q;

endmodule

// File: rtl/cfg_logic_element.sv
// Module: top of the configurable logic element.
// The scan chain holds the configuration. The decoder splits it into fields.
// One selector per table input feeds the lookup table. The output stage
// registers or bypasses the result.
// Feedback (code PIN_NUM) is taken from the flip-flop, so no
// combinational loop can form whatever the mode bit says.
module cfg_logic_element #(
    parameter int PIN_NUM = 4,
    parameter int LUT_K   = 4,
    parameter int SEL_W   = 3
) (
    input  logic               scan_clk,
    input  logic               scan_en,
    input  logic               scan_din,
    output logic               scan_dout,
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIN_NUM-1:0] pin_in,
    output logic               le_out
);
    localparam int LUT_SIZE  = 1 << LUT_K;
    localparam int CHAIN_LEN = le_pkg::chain_len(LUT_K, SEL_W);

    logic [CHAIN_LEN-1:0]            chain_q;
    logic                            comb_mode;
    logic [LUT_K-1:0][SEL_W-1:0]     sel_codes;
    logic [LUT_SIZE-1:0]             lut_bits;
    logic [LUT_K-1:0]                lut_addr;
    logic                            lut_o;
    logic                            ff_q;

    // Configuration storage on the scan clock.
    le_scan_chain #(.LEN(CHAIN_LEN)) u_chain (
        .scan_clk (scan_clk),
        .scan_en  (scan_en),
        .scan_din (scan_din),
        .chain_q  (chain_q),
        .scan_dout(scan_dout)
    );

    // Field extraction.
    le_cfg_decode #(.LUT_K(LUT_K), .SEL_W(SEL_W), .LEN(CHAIN_LEN)) u_dec (
        .chain_q  (chain_q),
        .comb_mode(comb_mode),
        .sel_codes(sel_codes),
        .lut_bits (lut_bits)
    );

    // One selector per table address bit.
    for (genvar j = 0; j < LUT_K; j++) begin : g_in
        le_input_sel #(.PIN_NUM(PIN_NUM), .SEL_W(SEL_W)) u_sel (
            .pin_in(pin_in),
            .fb_in (ff_q),
            .code  (sel_codes[j]),
            .sel_o (lut_addr[j])
        );
    end

    // Table lookup.
    le_lut #(.LUT_K(LUT_K)) u_lut (
        .addr      (lut_addr),
        .table_bits(lut_bits),
        .lut_o     (lut_o)
    );

    // Output register and mode mux.
    le_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .comb_mode(comb_mode),
        .lut_o    (lut_o),
        .ff_q     (ff_q),
        .le_out   (le_out)
    );

endmodule

// File: rtl/le_checker.sv
// Module: assertion checker for cfg_logic_element, attached by bind below.
// Assumes the scan clock keeps running while rst_n is low, so that $past
// has a sample before the first enabled check.
module le_checker #(
    parameter int CHAIN_LEN = 29,
    parameter int LUT_K     = 4,
    parameter int SEL_W     = 3,
    parameter int PIN_NUM   = 4
) (
    input logic                        clk,
    input logic                        scan_clk,
    input logic                        rst_n,
    input logic                        scan_en,
    input logic                        scan_din,
    input logic                        scan_dout,
    input logic [CHAIN_LEN-1:0]        chain_q,
    input logic [LUT_K-1:0][SEL_W-1:0] sel_codes,
    input logic                        lut_bit0,
    input logic                        lut_o,
    input logic                        ff_q
);
    localparam int ZERO_CODE = PIN_NUM + 1;

    logic rst_was_low = 1'b0;
    logic all_forced;

    // R1: an enabled scan edge puts the serial input at the chain head.
    assert_scan_shift_R1: assert property (@(posedge scan_clk) disable iff (!rst_n)
        scan_en |=> chain_q[0] == $past(scan_din));

    // R2: without enable the chain holds.
    assert_scan_hold_R2: assert property (@(posedge scan_clk) disable iff (!rst_n)
        !scan_en |=> $stable(chain_q));

    // R3: readback presents the bit that was one place short of the end.
    assert_readback_R3: assert property (@(posedge scan_clk) disable iff (!rst_n)
        scan_en |=> scan_dout == $past(chain_q[CHAIN_LEN-2]));

    // R9: the flop takes the table value at each clock edge.
    assert_reg_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ff_q == $past(lut_o));

    // Track whether the last clock edge saw reset asserted.
    always @(posedge clk) rst_was_low <= !rst_n;

    // R10: after an edge with reset low, the flop reads 0.
    always @(negedge clk) begin
        if (rst_was_low) begin
            assert_reset_clear_R10: assert (ff_q == 1'b0);
        end
    end

    // Flag when every select code is in the forced-zero range.
    always_comb begin
        all_forced = 1'b1;
        for (int j = 0; j < LUT_K; j++) begin
            if (sel_codes[j] < SEL_W'(ZERO_CODE)) all_forced = 1'b0;
        end
    end

    // R7: all inputs forced to 0 means the table reads entry 0.
    always @(negedge clk) begin
        if (rst_n && all_forced) begin
            assert_forced_zero_R7: assert (lut_o == lut_bit0);
        end
    end

endmodule

bind cfg_logic_element le_checker #(
    .CHAIN_LEN(CHAIN_LEN), .LUT_K(LUT_K), .SEL_W(SEL_W), .PIN_NUM(PIN_NUM)
) chk_i (
    .clk      (clk),
    .scan_clk (scan_clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .scan_din (scan_din),
    .scan_dout(scan_dout),
    .chain_q  (chain_q),
    .sel_codes(sel_codes),
    .lut_bit0 (lut_bits[0]),
    .lut_o    (lut_o),
    .ff_q     (ff_q)
);

// File: tb/cfg_logic_element_tb.sv
// Bench: table of combinational vectors, then directed tests for the
// hold, readback, registered, reset and feedback cases.
module cfg_logic_element_tb_top;
    localparam int IMG_LEN = 29;

    typedef struct packed {
        logic            mode;
        logic [3:0][2:0] sel;
        logic [15:0]     lut;
        logic [3:0]      pins;
        logic            exp_out;
    } vec_t;

    // sel written as {sel3, sel2, sel1, sel0}
    localparam vec_t VECS [8] = '{
        '{1'b1, {3'd3, 3'd2, 3'd1, 3'd0}, 16'h8000, 4'hF,    1'b1},
        '{1'b1, {3'd3, 3'd2, 3'd1, 3'd0}, 16'h8000, 4'hE,    1'b0},
        '{1'b1, {3'd0, 3'd1, 3'd2, 3'd3}, 16'h0002, 4'b1000, 1'b1},
        '{1'b1, {3'd5, 3'd5, 3'd5, 3'd5}, 16'h0001, 4'hF,    1'b1},
        '{1'b1, {3'd7, 3'd6, 3'd7, 3'd6}, 16'hFFFE, 4'hF,    1'b0},
        '{1'b1, {3'd5, 3'd2, 3'd5, 3'd2}, 16'h0020, 4'b0100, 1'b1},
        '{1'b1, {3'd0, 3'd0, 3'd0, 3'd0}, 16'h8001, 4'b0001, 1'b1},
        '{1'b1, {3'd0, 3'd3, 3'd2, 3'd1}, 16'h6996, 4'b0111, 1'b1}
    };

    logic       scan_clk = 1'b0;
    logic       clk = 1'b0;
    logic       scan_en = 1'b0;
    logic       scan_din = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_in = 4'h0;
    logic       scan_dout;
    logic       le_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [IMG_LEN-1:0] captured;

    cfg_logic_element dut_i (
        .scan_clk (scan_clk),
        .scan_en  (scan_en),
        .scan_din (scan_din),
        .scan_dout(scan_dout),
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .le_out   (le_out)
    );

    // 125 MHz user clock and a scan clock of the same rate, offset in phase.
    always #4ns scan_clk = ~scan_clk;
    initial begin
        #2ns;
        forever #4ns clk = ~clk;
    end

    // Build an image from fields as laid out in R1.
    function automatic logic [IMG_LEN-1:0] make_img(input logic mode,
                                                    input logic [3:0][2:0] sel,
                                                    input logic [15:0] lut);
        logic [IMG_LEN-1:0] img;
        img[0] = mode;
        for (int j = 0; j < 4; j++) begin
            img[1 + 3*j] = sel[j][2];
            img[2 + 3*j] = sel[j][1];
            img[3 + 3*j] = sel[j][0];
        end
        for (int k = 0; k < 16; k++) img[13 + k] = lut[k];
        return img;
    endfunction

    // Record one check; print a FAIL line on mismatch.
    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Shift a full image in (index 28 first), capturing scan_dout before each edge.
    task automatic load_img(input logic [IMG_LEN-1:0] img);
        for (int i = IMG_LEN - 1; i >= 0; i--) begin
            @(negedge scan_clk);
            captured[IMG_LEN-1-i] = scan_dout;
            scan_din = img[i];
            scan_en  = 1'b1;
        end
        @(negedge scan_clk);
        scan_en = 1'b0;
    endtask

    // Advance one user clock edge and sample mid-period.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [IMG_LEN-1:0] img_a;
        logic [IMG_LEN-1:0] img_b;
        logic [IMG_LEN-1:0] exp_cap;
        repeat (4) tick();
        rst_n = 1'b1;

        // Table walk: R1 R4 R5 R7 R8
        foreach (VECS[v]) begin
            load_img(make_img(VECS[v].mode, VECS[v].sel, VECS[v].lut));
            pin_in = VECS[v].pins;
            #1ns;
            check(32'(le_out), 32'(VECS[v].exp_out), $sformatf("R4 R5 R7 R8 vector %0d", v));
        end

        // R8: combinational response to a pin change, no clock needed (vector 7 config).
        pin_in = 4'b0110; // addr bits: pin1=1, pin2=1, pin3=0, pin0=0 -> 3, parity 0
        #1ns;
        check(32'(le_out), 32'd0, "R8 pin change");

        // R2: disabled scan edges with toggling data, plus user clock edges.
        pin_in = 4'b0111;
        for (int n = 0; n < 10; n++) begin
            @(negedge scan_clk);
            scan_din = n[0];
        end
        tick();
        #1ns;
        check(32'(le_out), 32'd1, "R2 hold output");

        // R3: readback of vector 7 while loading a registered AND image.
        img_a = make_img(VECS[7].mode, VECS[7].sel, VECS[7].lut);
        img_b = make_img(1'b0, {3'd3, 3'd2, 3'd1, 3'd0}, 16'h8000);
        load_img(img_b);
        for (int n = 0; n < IMG_LEN; n++) exp_cap[n] = img_a[IMG_LEN-1-n];
        check(32'(captured), 32'(exp_cap), "R3 readback R2 config kept");

        // R10: reset clears the flop even with the table reading 1.
        pin_in = 4'hF;
        rst_n = 1'b0;
        tick();
        check(32'(le_out), 32'd0, "R10 reset clear");
        tick();
        check(32'(le_out), 32'd0, "R10 reset priority");
        rst_n = 1'b1;
        #1ns;
        check(32'(le_out), 32'd0, "R9 no edge no change");
        tick();
        check(32'(le_out), 32'd1, "R9 registered capture");
        pin_in = 4'h0;
        #1ns;
        check(32'(le_out), 32'd1, "R9 holds between edges");
        tick();
        check(32'(le_out), 32'd0, "R9 second capture");

        // R1: second readback returns the registered image in shift-in order.
        load_img(make_img(1'b0, {3'd5, 3'd5, 3'd5, 3'd4}, 16'h0001));
        for (int n = 0; n < IMG_LEN; n++) exp_cap[n] = img_b[IMG_LEN-1-n];
        check(32'(captured), 32'(exp_cap), "R1 R3 image length and order");

        // R6: feedback through code 4 with table = inverter on address bit 0.
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check(32'(le_out), 32'd0, "R6 start");
        tick();
        check(32'(le_out), 32'd1, "R6 toggle 1");
        tick();
        check(32'(le_out), 32'd0, "R6 toggle 2");
        tick();
        check(32'(le_out), 32'd1, "R6 toggle 3");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #800us;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule